// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets a host controller read and write a bank of 8-bit configuration registers over a four-wire serial link. The wires are an active-low select, a serial clock, a data line that can carry data in both directions (brought out as a separate input, output and output-enable so that the pad sits outside the block), and a second data-out line that repeats the read data. All link inputs are brought into the system clock domain by synchronizers. The link protocol then runs as logic sampled at the system clock. Because of this, the system clock must run several times faster than the serial clock.

Every transaction opens with an 8-bit command. The command names the direction, a burst length of one to four bytes and a 5-bit starting register. Data bytes follow. After each byte the register pointer moves down by one, and it wraps from 0 to 31. A write burst stores each completed byte. A read burst shifts out the addressed register, most significant bit first. Only the lowest `IMPL_REGS` addresses hold storage. Each of them has a reset value derived from the parameter `RST_BASE`. An asynchronous active-low reset reloads those values.

Top module: `spi_cfg_port`

## Requirements
- R1: The command byte is received most significant bit first on rising serial-clock edges, with bit 7 the direction (0 = write, 1 = read), bits 6:5 the burst code and bits 4:0 the first register address.
- R2: In a write, each data byte is received D7 first on rising serial-clock edges and is stored into the current register once its eighth bit arrives.
- R3: In a read, each bit of the current register is presented on `sdio_o` after a falling serial-clock edge, D7 first, starting with the falling edge that follows the last command bit. The host samples it on the next rising edge.
- R4: Burst code 00, 01, 10, 11 transfers 1, 2, 3, 4 data bytes. Serial clocks after the last byte of the burst neither store data nor drive the data line.
- R5: The register pointer decreases by one after every completed data byte, wrapping from address 0 to address 31.
- R6: `sdio_oe` is high only while the data bytes of a read burst are being transferred. It is low during the command byte, during writes, after the burst and while the select is high.
- R7: `sdo` equals `sdio_o` whenever `sdio_oe` is high and is 0 otherwise.
- R8: Raising the select at any time ends the transaction and clears the bit and byte counts. A data byte that has fewer than eight bits received is discarded, while bytes already completed stay stored.
- R9: Addresses `IMPL_REGS` (default 24) through 31 read as 0x00, and writes to them have no effect.
- R10: While `rst_n` is low, implemented register i holds `RST_BASE ^ i` (default `RST_BASE` = 0x5A) and `sdio_oe` is low. The reset takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial link is oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset; reloads register reset values |
| cs_n | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Input side of the bidirectional data line |
| sdio_o | output | 1 | Output side of the bidirectional data line (read data) |
| sdio_oe | output | 1 | Output enable for the bidirectional data line; low means tri-stated |
| sdo | output | 1 | Separate data-out line repeating the read data |

## Verification
The checker evaluates several properties on every system clock. It confirms that the data-line enable falls within a cycle of the synchronized select going inactive and is only high in a data phase. It confirms that read data changes only on a detected falling serial-clock edge. It confirms that a register store happens only on a rising edge inside a selected data phase, that the pointer only ever steps down by one within a burst, and that addresses without storage return zero. What these properties cannot show is whether the right value reaches the right register. The bench covers that: it runs write bursts followed by read-back, bursts that cross address 0, extra clocks after a burst ends, selects dropped partway through a byte, writes to addresses without storage, and a reset in the middle of operation. A reference register image inside the bench is updated from the requirements and compared against what is read back.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;
    localparam int NUM_ADDR = 1 << ADDR_W;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    // Command byte layout: direction in the top bit, then burst code, then address.
    typedef struct packed {
        logic              is_read;
        logic [1:0]        burst;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        return cmd_t'(b);
    endfunction

    function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
        return a - ADDR_W'(1);
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(input logic [BYTE_W-1:0] base,
                                                      input int idx);
        return base ^ BYTE_W'(idx);
    endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sdi_s,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b100; // {cs_n, sclk, sdi}

    logic [STAGES-1:0][NSIG-1:0] stg;
    logic                        sclk_d;
    logic [NSIG-1:0]             last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg    <= {STAGES{IDLE_LVL}};
            sclk_d <= 1'b0;
        end else begin
            stg[0] <= {cs_n, sclk, sdi};
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            sclk_d <= stg[STAGES-1][1];
        end
    end

    assign last    = stg[STAGES-1];
    assign cs_act  = ~last[2];
    assign sdi_s   = last[0];
    assign rise_ev = last[1] & ~sclk_d;
    assign fall_ev = ~last[1] & sclk_d;

endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sdi,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              in_data
);
    phase_t            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        shreg;
    logic [1:0]        left;
    logic              is_rd;
    logic              dout;
    logic [BYTE_W-1:0] nxt_byte;
    logic              byte_full;
    cmd_t              cmd;

    assign nxt_byte  = {shreg, sdi};
    assign byte_full = rise_ev && (bit_cnt == 3'd7);
    assign cmd       = decode_cmd(nxt_byte);
    assign wr_en     = cs_act && (phase == PH_DATA) && !is_rd && byte_full;
    assign wr_data   = nxt_byte;
    assign in_data   = (phase == PH_DATA);
    assign sdio_oe   = (phase == PH_DATA) && is_rd;
    assign sdio_o    = dout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            shreg    <= '0;
            left     <= '0;
            is_rd    <= 1'b0;
            dout     <= 1'b0;
            cur_addr <= '0;
        end else if (!cs_act) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            left    <= '0;
            is_rd   <= 1'b0;
            dout    <= 1'b0;
        end else begin
            if (rise_ev && phase != PH_DONE) begin
                shreg   <= nxt_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_full) begin
                    if (phase == PH_CMD) begin
                        is_rd    <= cmd.is_read;
                        left     <= cmd.burst;
                        cur_addr <= cmd.addr;
                        phase    <= PH_DATA;
                    end else begin
                        cur_addr <= addr_step(cur_addr);
                        if (left == 2'd0) phase <= PH_DONE;
                        else              left  <= left - 2'd1;
                    end
                end
            end
            if (fall_ev && phase == PH_DATA && is_rd) begin
                dout <= rd_data[3'd7 - bit_cnt];
            end
        end
    end

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int              IMPL_REGS = 24,
    parameter logic [BYTE_W-1:0] RST_BASE = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int FLAT_W = IMPL_REGS * BYTE_W;

    logic [FLAT_W-1:0] flat;

    generate
        for (genvar i = 0; i < IMPL_REGS; i++) begin : g_reg
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reg_default(RST_BASE, i);
                else if (wr_en && wr_addr == ADDR_W'(i))
                    q <= wr_data;
            end
            assign flat[i*BYTE_W +: BYTE_W] = q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < IMPL_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = flat[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                IMPL_REGS   = 24,
    parameter logic [BYTE_W-1:0] RST_BASE    = 8'h5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe,
    output logic sdo
);
    logic              cs_act;
    logic              sdi_s;
    logic              rise_ev;
    logic              fall_ev;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              in_data;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdi     (sdio_i),
        .cs_act  (cs_act),
        .sdi_s   (sdi_s),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    spi_cfg_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sdi      (sdi_s),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .rd_data  (rd_data),
        .cur_addr (cur_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sdio_o   (sdio_o),
        .sdio_oe  (sdio_oe),
        .in_data  (in_data)
    );

    spi_cfg_regbank #(.IMPL_REGS(IMPL_REGS), .RST_BASE(RST_BASE)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cur_addr),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

    assign sdo = sdio_oe & sdio_o;

endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
    parameter int IMPL_REGS = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       rise_ev,
    input logic       fall_ev,
    input logic       wr_en,
    input logic [4:0] cur_addr,
    input logic       in_data,
    input logic [7:0] rd_data,
    input logic       sdio_o,
    input logic       sdio_oe
);
    p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdio_oe);

    p_oe_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> in_data);

    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && !fall_ev) |=> (!sdio_oe || $stable(sdio_o)));

    p_store_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cs_act && rise_ev && in_data));

    p_addr_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data) && cur_addr != $past(cur_addr))
            |-> cur_addr == $past(cur_addr) - 5'd1);

    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_addr) >= IMPL_REGS) |-> rd_data == 8'h00);

endmodule

bind spi_cfg_port spi_cfg_port_chk #(.IMPL_REGS(IMPL_REGS)) u_chk (.*);

// File: tb/test_spi_cfg_port.sv
module test_spi_cfg_port;
    localparam int        IMPL = 24;
    localparam logic [7:0] BASE = 8'h5A;
    localparam int        HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo;

    always #2 clk = ~clk;

    spi_cfg_port #(.IMPL_REGS(IMPL), .RST_BASE(BASE)) i_spi_cfg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] model [32];
    logic [7:0] tx_buf [4];
    logic [7:0] rx_buf [4];
    int oe_cmd_bad, oe_data_bad, oe_extra_bad, sdo_bad;

    function automatic logic [7:0] dflt(input int a);
        return (a < IMPL) ? (BASE ^ 8'(a)) : 8'h00;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 32; a++) model[a] = dflt(a);
    endtask

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic got, output logic oe,
                            output logic so);
        sdio_i = b;
        clk_wait(HALF);
        got = sdio_o;
        oe  = sdio_oe;
        so  = sdo;
        sclk = 1'b1;
        clk_wait(HALF);
        sclk = 1'b0;
    endtask

    task automatic xfer(input bit rd, input int n, input logic [4:0] addr,
                        input int data_bits, input int extra_bits);
        logic [7:0] cmd;
        logic got, oe, so;
        logic [4:0] a;
        cmd = {rd, 2'(n - 1), addr};
        oe_cmd_bad = 0; oe_data_bad = 0; oe_extra_bad = 0; sdo_bad = 0;
        for (int k = 0; k < 4; k++) rx_buf[k] = 8'h00;
        cs_n = 1'b0;
        clk_wait(HALF);
        for (int i = 7; i >= 0; i--) begin
            send_bit(cmd[i], got, oe, so);
            if (oe) oe_cmd_bad++;
        end
        for (int k = 0; k < data_bits; k++) begin
            int bi;
            bi = 7 - (k % 8);
            send_bit(rd ? 1'b0 : tx_buf[k/8][bi], got, oe, so);
            if (rd) begin
                rx_buf[k/8][bi] = got;
                if (!oe) oe_data_bad++;
                if (so !== got) sdo_bad++;
            end else if (oe) begin
                oe_data_bad++;
            end
        end
        for (int k = 0; k < extra_bits; k++) begin
            send_bit(1'b1, got, oe, so);
            if (oe || so) oe_extra_bad++;
        end
        clk_wait(HALF);
        cs_n = 1'b1;
        clk_wait(2 * HALF);
        if (!rd) begin
            a = addr;
            for (int k = 0; k < data_bits / 8; k++) begin
                if (int'(a) < IMPL) model[a] = tx_buf[k];
                a = a - 5'd1;
            end
        end
    endtask

    task automatic read_cmp(input string req, input int n, input logic [4:0] addr);
        logic [4:0] a;
        xfer(1'b1, n, addr, n * 8, 0);
        a = addr;
        for (int k = 0; k < n; k++) begin
            check(req, $sformatf("read addr %0d", a), rx_buf[k], model[a]);
            a = a - 5'd1;
        end
        check("R6", "enable during read data", 8'(oe_data_bad), 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        clk_wait(4);
        // R10: outputs quiet in reset
        check("R10", "oe in reset", {7'b0, sdio_oe}, 8'h00);
        rst_n = 1'b1;
        clk_wait(4);
        check("R6", "oe idle", {7'b0, sdio_oe}, 8'h00);
        check("R7", "sdo idle", {7'b0, sdo}, 8'h00);

        // R10 / R9 / R1 / R3: every address read singly after reset
        for (int a = 0; a < 32; a++) begin
            xfer(1'b1, 1, 5'(a), 8, 0);
            check(a < IMPL ? "R10" : "R9", $sformatf("reset value %0d", a),
                  rx_buf[0], dflt(a));
        end
        check("R6", "enable low in command byte", 8'(oe_cmd_bad), 8'h00);

        // R2 R4 R5 R9: 4-byte write from 2 crosses 0 into 31 (no storage)
        tx_buf[0] = 8'hC3; tx_buf[1] = 8'h81; tx_buf[2] = 8'h7E; tx_buf[3] = 8'h99;
        xfer(1'b0, 4, 5'd2, 32, 0);
        check("R6", "enable low in write", 8'(oe_data_bad), 8'h00);
        read_cmp("R5", 4, 5'd2);
        read_cmp("R9", 1, 5'd31);

        // R4: one-byte write followed by extra clocks must not touch addr 9
        tx_buf[0] = 8'hA5;
        xfer(1'b0, 1, 5'd10, 8, 8);
        read_cmp("R4", 2, 5'd10);

        // R4 R6: extra clocks after a read burst leave the line released
        xfer(1'b1, 2, 5'd6, 16, 12);
        check("R4", "enable after burst", 8'(oe_extra_bad), 8'h00);
        check("R3", "burst byte 0", rx_buf[0], model[6]);
        check("R3", "burst byte 1", rx_buf[1], model[5]);

        // R8: abort after 12 data bits; byte 0 kept, partial byte 1 dropped
        tx_buf[0] = 8'h3C; tx_buf[1] = 8'hF0;
        xfer(1'b0, 2, 5'd15, 12, 0);
        read_cmp("R8", 2, 5'd15);
        // R8: abort during the command byte, then a clean read
        cs_n = 1'b0; clk_wait(HALF);
        for (int i = 0; i < 5; i++) begin
            logic g, o, s;
            send_bit(1'b0, g, o, s);
        end
        clk_wait(HALF); cs_n = 1'b1; clk_wait(2 * HALF);
        read_cmp("R8", 3, 5'd20);

        // R9: write to an address without storage
        tx_buf[0] = 8'h77;
        xfer(1'b0, 1, 5'd28, 8, 0);
        read_cmp("R9", 1, 5'd28);

        // R1 R2 R3 R5 R7: random bursts
        for (int t = 0; t < 70; t++) begin
            bit rd;
            int n;
            logic [4:0] ad;
            rd = 1'($urandom % 2);
            n  = 1 + int'($urandom % 4);
            ad = 5'($urandom % 32);
            for (int k = 0; k < 4; k++) tx_buf[k] = 8'($urandom);
            if (rd) begin
                read_cmp("R3", n, ad);
                check("R7", "sdo mirror", 8'(sdo_bad), 8'h00);
            end else begin
                xfer(1'b0, n, ad, n * 8, 0);
                check("R2", "enable low in write", 8'(oe_data_bad), 8'h00);
            end
        end

        // R10: reset in mid-operation restores defaults
        clk_wait(1);
        #1 rst_n = 1'b0;
        #1 check("R10", "oe during reset", {7'b0, sdio_oe}, 8'h00);
        clk_wait(3);
        rst_n = 1'b1;
        model_reset();
        clk_wait(4);
        for (int a = 23; a >= 0; a -= 4) read_cmp("R10", 4, 5'(a));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule